// File: doc/BRIEF.md
# Sample Playback Channel Control Registers

This block holds the control state of a delta-modulated sample playback channel. A processor writes four byte-wide register offsets: a setup byte (interrupt enable, looping, rate select), a direct output-level load, a sample start address and a sample length. A separate status write carries a single channel-enable bit that stops or restarts playback. The start address and the length are both stored in expanded form, built from the written byte by a fixed shift and a fixed OR pattern.

A fetch-acknowledge input stands in for the memory fetch engine. Each accepted acknowledge moves the current fetch address forward and counts down the bytes still to be fetched. When the count runs out, the channel either starts over from the stored start address (looping) or raises its interrupt flag (when interrupts are enabled). The rate index and output level are only held and presented; the rate timer and the delta shifter live elsewhere.

Top module: `sample_ctrl_regs`

## Requirements
- R1: A write with `wr_off` = 0 loads `irq_en` from data bit 7, `loop_en` from data bit 6 and `rate_idx` from data bits 3:0, visible one cycle after the write.
- R2: A write with `wr_off` = 0 and data bit 7 = 0 clears `irq_flag` in the following cycle, taking priority over a same-cycle end-of-sample event.
- R3: A write with `wr_off` = 1 loads `level` with data bits 6:0.
- R4: A write with `wr_off` = 2 sets `start_addr` to 16'hC000 OR (data << 6).
- R5: A write with `wr_off` = 3 sets `samp_len` to (data << 4) OR 1, a 12-bit value.
- R6: A status write (`stat_wr` = 1) with `stat_en` = 0 sets `remain` to 0 and `buf_empty` to 1.
- R7: A status write with `stat_en` = 1 while `remain` = 0 loads `remain` from `samp_len` and `cur_addr` from `start_addr`; while `remain` is nonzero it changes neither.
- R8: A `fetch_ack` while `remain` is nonzero and no status write is present decrements `remain`, clears `buf_empty` and increments `cur_addr`, with 16'hFFFF followed by 16'h8000; a `fetch_ack` while `remain` = 0 changes nothing.
- R9: When an accepted fetch takes `remain` from 1 to 0: if `loop_en` is 1, `remain` reloads from `samp_len` and `cur_addr` from `start_addr` and `irq_flag` is untouched; otherwise, if `irq_en` is 1, `irq_flag` becomes 1.
- R10: After reset every register and `irq_flag` read 0 and `buf_empty` reads 1.
- R11: A status write in the same cycle as `fetch_ack` wins: the fetch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 2 | Register offset of the write |
| wr_data | input | 8 | Write data |
| stat_wr | input | 1 | Status write strobe |
| stat_en | input | 1 | Channel enable bit of the status write |
| fetch_ack | input | 1 | One sample byte has been fetched |
| irq_en | output | 1 | Interrupt enable |
| loop_en | output | 1 | Loop flag |
| rate_idx | output | 4 | Rate index |
| level | output | 7 | Output level |
| start_addr | output | 16 | Sample start address |
| samp_len | output | 12 | Sample length in bytes |
| cur_addr | output | 16 | Current fetch address |
| remain | output | 12 | Bytes remaining |
| buf_empty | output | 1 | Sample buffer empty |
| irq_flag | output | 1 | Channel interrupt flag |

## Verification
The hardest state to reach is the address wrap from 16'hFFFF to 16'h8000, since the highest start address is 16'hFFC0 and the channel must be kept running for 63 fetches without the count expiring. A directed sequence programs the top start address and a 65-byte length, restarts playback and acknowledges fetches until the wrap and then the end of the sample, with looping off and interrupts on. Random traffic then mixes writes, status writes and acknowledges, with short lengths favoured so that end-of-sample, loop restarts and same-cycle collisions occur often.

// File: rtl/sample_ctrl_regs.sv
module sample_ctrl_regs #(
  parameter logic [15:0] START_BASE = 16'hC000,
  parameter logic [15:0] WRAP_BASE  = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_off,
  input  logic [7:0]  wr_data,
  input  logic        stat_wr,
  input  logic        stat_en,
  input  logic        fetch_ack,
  output logic        irq_en,
  output logic        loop_en,
  output logic [3:0]  rate_idx,
  output logic [6:0]  level,
  output logic [15:0] start_addr,
  output logic [11:0] samp_len,
  output logic [15:0] cur_addr,
  output logic [11:0] remain,
  output logic        buf_empty,
  output logic        irq_flag
);

  logic wr_setup, wr_level, wr_start, wr_len;
  logic fetch_go, fetch_last;
  logic [15:0] addr_inc;

  assign wr_setup   = wr_en && (wr_off == 2'd0);
  assign wr_level   = wr_en && (wr_off == 2'd1);
  assign wr_start   = wr_en && (wr_off == 2'd2);
  assign wr_len     = wr_en && (wr_off == 2'd3);
  assign fetch_go   = fetch_ack && !stat_wr && (remain != '0);
  assign fetch_last = fetch_go && (remain == 12'd1);
  assign addr_inc   = (cur_addr == 16'hFFFF) ? WRAP_BASE : cur_addr + 16'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en     <= 1'b0;
      loop_en    <= 1'b0;
      rate_idx   <= '0;
      level      <= '0;
      start_addr <= '0;
      samp_len   <= '0;
    end else begin
      if (wr_setup) begin
        irq_en   <= wr_data[7];
        loop_en  <= wr_data[6];
        rate_idx <= wr_data[3:0];
      end
      if (wr_level) level      <= wr_data[6:0];
      if (wr_start) start_addr <= START_BASE | {2'b00, wr_data, 6'b0};
      if (wr_len)   samp_len   <= {wr_data, 4'h1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_flag <= 1'b0;
    else if (wr_setup && !wr_data[7])
      irq_flag <= 1'b0;
    else if (fetch_last && !loop_en && irq_en)
      irq_flag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remain    <= '0;
      buf_empty <= 1'b1;
    end else if (stat_wr) begin
      if (!stat_en) begin
        remain    <= '0;
        buf_empty <= 1'b1;
      end else if (remain == '0) begin
        remain   <= samp_len;
        cur_addr <= start_addr;
      end
    end else if (fetch_go) begin
      buf_empty <= 1'b0;
      if (fetch_last && loop_en) begin
        remain   <= samp_len;
        cur_addr <= start_addr;
      end else begin
        remain   <= remain - 12'd1;
        cur_addr <= addr_inc;
      end
    end
  end

endmodule

module sample_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_off,
  input logic [7:0]  wr_data,
  input logic        stat_wr,
  input logic        stat_en,
  input logic        fetch_ack,
  input logic        irq_en,
  input logic        loop_en,
  input logic [6:0]  level,
  input logic [15:0] start_addr,
  input logic [11:0] samp_len,
  input logic [15:0] cur_addr,
  input logic [11:0] remain,
  input logic        buf_empty,
  input logic        irq_flag
);

  AST_SETUP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_off == 2'd0 |=> irq_en == $past(wr_data[7]) && loop_en == $past(wr_data[6])); // R1

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_off == 2'd0 && !wr_data[7] |=> !irq_flag); // R2

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_off == 2'd1 |=> level == $past(wr_data[6:0])); // R3

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_off == 2'd2 |=> start_addr == (16'hC000 | {2'b00, $past(wr_data), 6'b0})); // R4

  AST_LEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_off == 2'd3 |=> samp_len == {$past(wr_data), 4'h1}); // R5

  AST_DISABLE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && !stat_en |=> remain == '0 && buf_empty); // R6

  AST_NO_RESTART_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && stat_en && remain != '0 |=> $stable(remain) && $stable(cur_addr)); // R7

  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !stat_wr && remain > 12'd1 && cur_addr == 16'hFFFF |=> cur_addr == 16'h8000); // R8

  AST_IDLE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !stat_wr && remain == '0 |=> $stable(remain) && $stable(cur_addr)); // R8

  AST_END_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ack && !stat_wr && remain == 12'd1 && !loop_en && irq_en && !(wr_en && wr_off == 2'd0)
    |=> irq_flag); // R9

  AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && stat_en && fetch_ack && remain != '0 |=> $stable(remain)); // R11

endmodule

bind sample_ctrl_regs sample_ctrl_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
  .stat_wr(stat_wr), .stat_en(stat_en), .fetch_ack(fetch_ack),
  .irq_en(irq_en), .loop_en(loop_en), .level(level), .start_addr(start_addr),
  .samp_len(samp_len), .cur_addr(cur_addr), .remain(remain),
  .buf_empty(buf_empty), .irq_flag(irq_flag)
);

// File: tb/sample_ctrl_regs_tb.sv
`timescale 1ns/1ps
module sample_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_off = '0;
  logic [7:0]  wr_data = '0;
  logic        stat_wr = 1'b0;
  logic        stat_en = 1'b0;
  logic        fetch_ack = 1'b0;
  logic        irq_en, loop_en, buf_empty, irq_flag;
  logic [3:0]  rate_idx;
  logic [6:0]  level;
  logic [15:0] start_addr, cur_addr;
  logic [11:0] samp_len, remain;

  sample_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .stat_wr(stat_wr), .stat_en(stat_en), .fetch_ack(fetch_ack),
    .irq_en(irq_en), .loop_en(loop_en), .rate_idx(rate_idx), .level(level),
    .start_addr(start_addr), .samp_len(samp_len), .cur_addr(cur_addr),
    .remain(remain), .buf_empty(buf_empty), .irq_flag(irq_flag)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic        m_irq_en, m_loop, m_empty, m_irq;
  logic [3:0]  m_rate;
  logic [6:0]  m_level;
  logic [15:0] m_start, m_addr;
  logic [11:0] m_len, m_rem;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] next_addr(input logic [15:0] a);
    return (a == 16'hFFFF) ? 16'h8000 : a + 16'd1;
  endfunction

  task automatic model_step();
    logic go, last;
    if (!rst_n) begin
      {m_irq_en, m_loop, m_irq} = '0;
      m_rate = '0; m_level = '0; m_start = '0; m_len = '0; m_addr = '0; m_rem = '0;
      m_empty = 1'b1;
      return;
    end
    go   = fetch_ack && !stat_wr && m_rem != 0;
    last = go && m_rem == 12'd1;
    if (wr_en && wr_off == 2'd0 && !wr_data[7]) m_irq = 1'b0;
    else if (last && !m_loop && m_irq_en) m_irq = 1'b1;
    if (stat_wr) begin
      if (!stat_en) begin m_rem = 0; m_empty = 1'b1; end
      else if (m_rem == 0) begin m_rem = m_len; m_addr = m_start; end
    end else if (go) begin
      m_empty = 1'b0;
      if (last && m_loop) begin m_rem = m_len; m_addr = m_start; end
      else begin m_rem = m_rem - 1; m_addr = next_addr(m_addr); end
    end
    if (wr_en) case (wr_off)
      2'd0: begin m_irq_en = wr_data[7]; m_loop = wr_data[6]; m_rate = wr_data[3:0]; end
      2'd1: m_level = wr_data[6:0];
      2'd2: m_start = 16'hC000 | {2'b00, wr_data, 6'b0};
      default: m_len = {wr_data, 4'h1};
    endcase
  endtask

  task automatic compare_all();
    check("R1 irq_en", irq_en, m_irq_en);
    check("R1 loop_en", loop_en, m_loop);
    check("R1 rate_idx", rate_idx, m_rate);
    check("R3 level", level, m_level);
    check("R4 start_addr", start_addr, m_start);
    check("R5 samp_len", samp_len, m_len);
    check("R8 cur_addr", cur_addr, m_addr);
    check("R8 remain", remain, m_rem);
    check("R6 buf_empty", buf_empty, m_empty);
    check("R9 irq_flag", irq_flag, m_irq);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    wr_en = 0; stat_wr = 0; fetch_ack = 0;
  endtask

  task automatic wr(input logic [1:0] off, input logic [7:0] d);
    wr_en = 1; wr_off = off; wr_data = d; cyc();
  endtask

  task automatic stat(input logic en);
    stat_wr = 1; stat_en = en; cyc();
  endtask

  task automatic fetch();
    fetch_ack = 1; cyc();
  endtask

  initial begin
    process::self().srandom(32'd7391);
    model_step();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    check("R10 remain", remain, 0);
    check("R10 cur_addr", cur_addr, 0);
    check("R10 irq_flag", irq_flag, 0);
    check("R10 buf_empty", buf_empty, 1);
    check("R10 samp_len", samp_len, 0);

    // R1 setup fields
    wr(2'd0, 8'hCA);
    check("R1 irq_en set", irq_en, 1);
    check("R1 loop set", loop_en, 1);
    check("R1 rate", rate_idx, 4'hA);
    wr(2'd1, 8'hFF);
    check("R3 level low 7 bits", level, 7'h7F);
    wr(2'd2, 8'hFF);
    check("R4 top start", start_addr, 16'hFFC0);
    wr(2'd3, 8'h04);
    check("R5 length", samp_len, 12'h041);

    // R7 restart from idle, wrap path R8, end R9
    wr(2'd0, 8'h80);
    stat(1'b1);
    check("R7 reload remain", remain, 12'h041);
    check("R7 reload addr", cur_addr, 16'hFFC0);
    fetch();
    check("R8 buf_empty cleared", buf_empty, 0);
    stat(1'b1);
    check("R7 busy no reload", remain, 12'h040);
    for (int i = 0; i < 62; i++) fetch();
    check("R8 at top", cur_addr, 16'hFFFF);
    fetch();
    check("R8 wrap", cur_addr, 16'h8000);
    check("R8 remain after wrap", remain, 12'h001);
    stat_wr = 1; stat_en = 1; fetch_ack = 1; cyc();
    check("R11 fetch ignored", remain, 12'h001);
    fetch();
    check("R9 end no loop", remain, 0);
    check("R9 irq raised", irq_flag, 1);
    fetch();
    check("R8 idle fetch", remain, 0);
    wr(2'd0, 8'h00);
    check("R2 irq cleared", irq_flag, 0);

    // R9 loop restart
    wr(2'd0, 8'hC0);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h10);
    stat(1'b1);
    fetch();
    check("R9 loop remain", remain, 12'h001);
    check("R9 loop addr", cur_addr, 16'hC400);
    check("R9 loop no irq", irq_flag, 0);
    stat(1'b0);
    check("R6 disable remain", remain, 0);
    check("R6 disable empty", buf_empty, 1);

    // R2 clear wins over same-cycle end event
    wr(2'd0, 8'h80);
    stat(1'b1);
    wr_en = 1; wr_off = 0; wr_data = 8'h00; fetch_ack = 1; cyc();
    check("R2 clear priority", irq_flag, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      wr_en = ($urandom_range(0, 99) < 25);
      wr_off = 2'($urandom_range(0, 3));
      wr_data = 8'($urandom);
      if (wr_off == 2'd3 && $urandom_range(0, 9) < 8) wr_data = wr_data & 8'h03;
      stat_wr = ($urandom_range(0, 99) < 6);
      stat_en = ($urandom_range(0, 99) < 75);
      fetch_ack = ($urandom_range(0, 99) < 50);
      cyc();
    end

    // R10 synchronous reset mid-run
    rst_n = 0; cyc(); rst_n = 1;
    check("R10 reset again", {remain, irq_flag, buf_empty}, {12'h0, 1'b0, 1'b1});

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule